// File: doc/BRIEF.md
# Byte-Level I2C Bus Master

This block is an I2C bus master that software steers one bus primitive at a time through a small 8-bit register port. A divider sets the SCL rate. Software then writes a command for a start condition, a stop condition or a byte read, or it writes a byte to be sent. While the block works on that primitive, software polls a busy flag. When the flag clears, software collects the acknowledge bit of a write or the byte captured by a read.

SCL and SDA are treated as open-drain lines. For each line the block provides an output-enable that pulls the line low, and it reads the line's level back on a separate input. Every SCL period is made of four quarter-phases of equal length. After releasing SCL, the block waits until the line actually reads high. A dedicated reset command returns the bus engine to idle at any time, so a locked bus can be recovered.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0, receive data reads 0, the divider reads 1, and both lines are released (SCL and SDA read high).
- R2: The divider is DIV_W bits wide and can be read and written. Address 0 holds bits 7:0. Address 1 holds the upper bits in its low bits, and its other bits read 0.
- R3: One SCL period lasts 4 times the divider value in clock cycles. A divider of 0 behaves as 1.
- R4: Writing address 2 issues a command. Bit 0 is bus reset, bit 1 is start, bit 2 is stop, bit 3 is read with ACK and bit 4 is read with NACK. If several bits are set, the lowest set bit wins.
- R5: A start from a released bus drives SDA low while SCL is high, then drives SCL low. A start on a bus that is already started releases SDA, then releases SCL, then drives SDA low while SCL is high, which gives a repeated start.
- R6: A stop drives SDA low, then releases SCL, then releases SDA while SCL is high. This leaves both lines released.
- R7: Writing address 3 sends the byte MSB first over eight SCL clocks, followed by a ninth clock with SDA released. During a byte, SDA changes only while SCL is driven low.
- R8: Status bit 1 is set to 1 if the target held SDA low at the ninth clock of the last byte write (ACK), and to 0 otherwise (NACK).
- R9: A read shifts in 8 bits, MSB first. The byte can then be read at address 4. On the ninth clock, SDA is driven low for read with ACK and left released for read with NACK.
- R10: Address 5 is status. Bit 0 (busy) is 1 from the cycle after an accepted command until the primitive ends. Bits 7:2 read 0.
- R11: A send or command write that arrives while busy, other than bus reset, has no effect.
- R12: Bus reset is accepted even while busy. In the next cycle, busy is 0 and both lines are released, and a later start runs as a fresh start.
- R13: After releasing SCL, the block holds its timing until SCL reads high. If SCL is stuck low, busy stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with the default DIV_W of 12 and DIV_INIT of 1. With these values, writing a wide pattern to the divider reaches its upper nibble, so the split across the two address halves is checked. Most byte traffic runs at divider 3, which puts the quarter-phase counter through a multi-cycle count. One byte runs at divider 0, which exercises the single-cycle quarter and the clamp of zero to one. Holding SCL low while a start is pending brings the wait-for-high stall and the bus reset recovery within reach.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int DIV_W = 12,
  parameter logic [DIV_W-1:0] DIV_INIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam logic [2:0] A_DIVL = 3'd0, A_DIVH = 3'd1, A_ACT = 3'd2,
                         A_TX = 3'd3, A_RX = 3'd4, A_STAT = 3'd5;
  localparam int HI_W = DIV_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_STOP, S_WRITE, S_READ} st_t;

  st_t             state;
  logic [DIV_W-1:0] div_r, qcnt, qlast;
  logic [1:0]      ph;
  logic [3:0]      bitn;
  logic [7:0]      shreg, rx_r;
  logic            ack_r, started, rd_ack;

  wire busy    = state != S_IDLE;
  wire act_wr  = reg_we && reg_addr == A_ACT;
  wire rst_cmd = act_wr && reg_wdata[0];
  wire act_go  = act_wr && !busy && !reg_wdata[0] && |reg_wdata[4:1];
  wire tx_go   = reg_we && reg_addr == A_TX && !busy;
  wire stall   = busy && ph == 2'd1 && !scl_i;
  wire adv     = busy && !stall && qcnt == qlast;
  wire in_byte = state == S_WRITE || state == S_READ;

  assign qlast = (div_r == '0) ? '0 : div_r - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_r <= DIV_INIT;
    else if (reg_we && reg_addr == A_DIVL) div_r[7:0] <= reg_wdata;
    else if (reg_we && reg_addr == A_DIVH) div_r[DIV_W-1:8] <= reg_wdata[HI_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; qcnt <= '0; ph <= '0; bitn <= '0; shreg <= '0;
      rx_r <= '0; ack_r <= 1'b0; started <= 1'b0; rd_ack <= 1'b0;
    end else if (rst_cmd) begin
      state <= S_IDLE; started <= 1'b0; qcnt <= '0; ph <= '0;
    end else if (act_go) begin
      qcnt <= '0; ph <= '0; bitn <= '0;
      if (reg_wdata[1]) state <= S_START;
      else if (reg_wdata[2]) state <= S_STOP;
      else begin state <= S_READ; rd_ack <= reg_wdata[3]; end
    end else if (tx_go) begin
      state <= S_WRITE; shreg <= reg_wdata; qcnt <= '0; ph <= '0; bitn <= '0;
    end else if (busy && !stall) begin
      if (qcnt != qlast) qcnt <= qcnt + 1'b1;
      else begin
        qcnt <= '0;
        ph   <= ph + 1'b1;
        if (in_byte && ph == 2'd2) begin
          if (bitn == 4'd8) begin
            if (state == S_WRITE) ack_r <= !sda_i;
          end else if (state == S_READ) shreg <= {shreg[6:0], sda_i};
        end
        if (ph == 2'd3) begin
          case (state)
            S_START: begin state <= S_IDLE; started <= 1'b1; end
            S_STOP:  begin state <= S_IDLE; started <= 1'b0; end
            default: begin
              if (state == S_WRITE) shreg <= {shreg[6:0], 1'b0};
              bitn <= bitn + 1'b1;
              if (bitn == 4'd8) begin
                state <= S_IDLE;
                if (state == S_READ) rx_r <= shreg;
              end
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    case (state)
      S_START: begin scl_oe = (ph == 2'd0) ? started : (ph == 2'd3); sda_oe = ph[1]; end
      S_STOP:  begin scl_oe = ph == 2'd0; sda_oe = !ph[1]; end
      S_WRITE: begin scl_oe = ph == 2'd0 || ph == 2'd3; sda_oe = bitn < 4'd8 && !shreg[7]; end
      S_READ:  begin scl_oe = ph == 2'd0 || ph == 2'd3; sda_oe = bitn == 4'd8 && rd_ack; end
      default: begin scl_oe = started; sda_oe = started; end
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_DIVL:  reg_rdata = div_r[7:0];
      A_DIVH:  reg_rdata = 8'(div_r[DIV_W-1:8]);
      A_RX:    reg_rdata = rx_r;
      A_STAT:  reg_rdata = {6'b0, ack_r, busy};
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (act_go || tx_go) |=> busy);

  a_r12_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (!busy && !scl_oe && !sda_oe));

  a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));

  a_r6_stop_leaves_free: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && adv && ph == 2'd3 && !rst_cmd) |=> (!busy && !scl_oe && !sda_oe));

  a_r5_start_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && adv && ph == 2'd3 && !rst_cmd) |=> (scl_oe && sda_oe));
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe, scl_line, sda_line, tgt_pull;
  logic scl_stuck = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int idx = -1, mode = 0, starts = 0, stops = 0;
  logic [8:0] cap = '0;
  logic tgt_ack = 1'b0;
  logic [7:0] tgt_data = '0;
  time t_prev = 0, t_last = 0;

  assign scl_line = !scl_oe && !scl_stuck;
  assign sda_line = !sda_oe && !tgt_pull;
  assign tgt_pull = (mode == 1 && idx == 8 && tgt_ack) ||
                    (mode == 2 && idx >= 0 && idx < 8 && !tgt_data[7-idx]);

  i2c_byte_master dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .scl_oe(scl_oe),
    .sda_i(sda_line), .sda_oe(sda_oe));

  always @(negedge sda_line) if (scl_line) begin starts++; idx = -1; end
  always @(posedge sda_line) if (scl_line) stops++;
  always @(negedge scl_line) idx = (idx >= 8) ? 0 : idx + 1;
  always @(posedge scl_line) begin
    t_prev = t_last; t_last = $time;
    if (idx >= 0 && idx <= 8) cap[8-idx] = sda_line;
  end

  localparam logic [9:0] VEC [6] = '{
    {1'b0, 8'hA5, 1'b1}, {1'b0, 8'h3C, 1'b0}, {1'b1, 8'h5A, 1'b1},
    {1'b1, 8'hC3, 1'b0}, {1'b0, 8'h00, 1'b1}, {1'b1, 8'hFF, 1'b1}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin @(negedge clk); rd(3'd5, s); n++; end while (s[0] && n < 20000);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    starts = 0; stops = 0;

    rd(3'd5, v); check(v == 8'h00, "R1 status", v, 0);
    rd(3'd4, v); check(v == 8'h00, "R1 rxdata", v, 0);
    rd(3'd0, v); check(v == 8'h01, "R1 divider", v, 1);
    check(scl_line && sda_line, "R1 lines", {scl_line, sda_line}, 3);

    wr(3'd0, 8'h34); wr(3'd1, 8'hFA);
    rd(3'd0, v); check(v == 8'h34, "R2 div low", v, 8'h34);
    rd(3'd1, v); check(v == 8'h0A, "R2 div high", v, 8'h0A);
    wr(3'd0, 8'h03); wr(3'd1, 8'h00);

    wr(3'd2, 8'h02);
    rd(3'd5, v); check(v == 8'h01, "R10 busy after start", v, 1);
    wait_idle();
    check(starts == 1, "R5 fresh start", starts, 1);
    check(!scl_line && !sda_line, "R5 lines low", {scl_line, sda_line}, 0);

    for (int i = 0; i < 6; i++) begin
      logic op, flag;
      logic [7:0] d;
      {op, d, flag} = VEC[i];
      if (!op) begin
        mode = 1; tgt_ack = flag;
        wr(3'd3, d);
        if (i == 0) begin wr(3'd3, 8'h00); wr(3'd2, 8'h04); end
        wait_idle(); mode = 0;
        check(cap[8:1] == d, "R7 sent byte", cap[8:1], d);
        rd(3'd5, v); check(v[1] == flag, "R8 ack bit", v[1], flag);
        if (i == 0) begin
          check(stops == 0, "R11 stop ignored while busy", stops, 0);
          check(t_last - t_prev == 240, "R3 period div3", int'(t_last - t_prev), 240);
        end
      end else begin
        mode = 2; tgt_data = d;
        wr(3'd2, flag ? 8'h08 : 8'h10);
        wait_idle(); mode = 0;
        rd(3'd4, v); check(v == d, "R9 read byte", v, d);
        check(cap[0] == !flag, "R9 master ack", cap[0], !flag);
      end
    end

    wr(3'd2, 8'h02); wait_idle();
    check(starts == 2, "R5 repeated start", starts, 2);

    wr(3'd0, 8'h00);
    mode = 1; tgt_ack = 1'b0;
    wr(3'd3, 8'h96); wait_idle(); mode = 0;
    check(cap[8:1] == 8'h96, "R7 byte div0", cap[8:1], 8'h96);
    check(t_last - t_prev == 80, "R3 div zero as one", int'(t_last - t_prev), 80);
    rd(3'd5, v); check(v[1] == 1'b0, "R8 nack", v[1], 0);
    wr(3'd0, 8'h03);

    wr(3'd2, 8'h06); wait_idle();
    check(starts == 3, "R4 lowest bit wins", starts, 3);
    check(stops == 0, "R4 no stop", stops, 0);

    wr(3'd2, 8'h04); wait_idle();
    check(stops == 1, "R6 stop seen", stops, 1);
    check(scl_line && sda_line, "R6 lines free", {scl_line, sda_line}, 3);

    scl_stuck = 1'b1;
    wr(3'd2, 8'h02);
    repeat (100) @(negedge clk);
    rd(3'd5, v); check(v == 8'h01, "R13 stall busy and R10 reserved", v, 1);
    wr(3'd2, 8'h1F);
    rd(3'd5, v); check(v[0] == 1'b0, "R12 reset clears busy", v[0], 0);
    scl_stuck = 1'b0;
    @(negedge clk);
    check(scl_line && sda_line, "R12 lines released", {scl_line, sda_line}, 3);
    wr(3'd2, 8'h02); wait_idle();
    check(starts == 4, "R12 fresh start after reset", starts, 4);
    wr(3'd2, 8'h04); wait_idle();
    check(stops == 2, "R6 final stop", stops, 2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule